// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down-counters that share one byte-wide register bus. Address 3 of the bus is a control port that selects a channel and either configures its operating mode or freezes a snapshot of its count; addresses 0 to 2 are the per-channel data ports. A count is always loaded as two bytes, low byte first and high byte second. Reads return two bytes in the same order, taken either from the live count or from a frozen snapshot. Each channel drives an output pin. The output of channel 2 also appears as one bit of a separate status byte, which the host uses as a speaker flag.

Counting advances on a tick of 1,193,180 Hz. A fractional accumulator derives this tick from the system clock and produces a one-cycle enable. Each channel is a small state machine with three states. In HALT the channel does not count. In RUN it decrements on every tick. In DONE a one-shot count has expired and holds. The transitions are as follows. A low-byte write moves any state to HALT. A high-byte write moves the channel to RUN when the loaded value is nonzero, and to HALT when it is zero. In mode 0, a tick that takes the count from 1 to 0 moves RUN to DONE. Control words that ask for an unsupported feature (read-back, single-byte access, BCD counting or another mode) change nothing and raise a one-cycle error pulse.

Top module: `interval_timer3`

## Requirements
- R1: A control write (address 3) decodes bits 7:6 as the channel select, bits 5:4 as the access code, bits 3:1 as the mode and bit 0 as the BCD flag. A select of 3 changes no channel and pulses `cmd_err` high for one cycle, in the cycle after the write.
- R2: Access code 0 is a latch command for the selected channel. Access code 3 means low byte then high byte. Access codes 1 and 2 change nothing and pulse `cmd_err`.
- R3: With access code 3, only modes 0, 2 and 3 with BCD=0 are stored. Any other mode, or BCD=1, keeps the previous mode and pulses `cmd_err`. A latch command never raises `cmd_err`.
- R4: A data write to a channel whose write pointer is at the low byte replaces count bits 7:0, enters HALT, drives the channel output low in the next cycle and moves the write pointer to the high byte.
- R5: A data write with the write pointer at the high byte replaces count bits 15:8, stores the 16-bit value as the period and returns the pointer to the low byte. The channel enters RUN only if that value is nonzero. In mode 3 the count is loaded with max(period/2, 1) instead of the period.
- R6: A latch command copies the current count into a snapshot and points reads at the low byte, but only when no snapshot is already held. A latch command issued while a snapshot is held has no effect.
- R7: While a snapshot is held, reads of the channel return its low byte and then its high byte. The second read releases the snapshot.
- R8: With no snapshot held, reads of a channel alternate between the low and the high byte of the live count. The read result appears on `bus_rdata` one cycle after the read and is held until the next read. Reading address 3 returns 0x00.
- R9: In mode 0, each tick in RUN decrements the count. The tick that leaves the count at 0 drives the output high and moves the channel to DONE, where the count stays at 0.
- R10: In mode 2, a tick at count 1 reloads the period and drives the output high. Any other tick in RUN decrements the count and drives the output low.
- R11: In mode 3, a tick at count 1 reloads max(period/2, 1) and inverts the output. Any other tick in RUN decrements the count.
- R12: `spkr_status` equals 0x20 (bit 5) while the channel 2 output is high, and 0x00 otherwise.
- R13: A phase accumulator starts at 0. In each system cycle it adds TICK_HZ, and subtracts CLK_HZ when it fires. The tick fires in a cycle where the accumulator is at least CLK_HZ−TICK_HZ. A data write to a channel takes priority over a tick in that same cycle.
- R14: After reset, every count, period, mode, pointer and snapshot is zero and every channel is in HALT. All outputs, `cmd_err`, `bus_rdata` and `spkr_status` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | 0..2 channel data, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cmd_err | output | 1 | One-cycle pulse on an unsupported control word |
| ch_out | output | NUM_CH | Channel output levels |
| spkr_status | output | 8 | Status byte carrying the channel 2 output |

## Verification
Each mode is tried on its own channel with a small period, so that the terminal-count hold of mode 0, the one-tick pulse of mode 2 and the half-period toggle of mode 3 can be told apart on the output pins and on the status byte. Reads are mixed with and without a snapshot. A second latch command issued after the count has moved shows whether an ignored latch overwrote the snapshot. Reads taken after the snapshot is released show whether the live count is being read again. A zero period, a low-byte write in the middle of a run and every class of rejected control word check that the channel halts, and that a rejected control word leaves its mode untouched.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    typedef enum logic [1:0] {
        CH_HALT = 2'd0,
        CH_RUN  = 2'd1,
        CH_DONE = 2'd2
    } ch_state_e;

    localparam logic [2:0] MODE_ONESHOT = 3'd0;
    localparam logic [2:0] MODE_RATE    = 3'd2;
    localparam logic [2:0] MODE_SQUARE  = 3'd3;

    localparam logic [1:0] ACC_LATCH = 2'd0;
    localparam logic [1:0] ACC_WORD  = 2'd3;
    localparam logic [1:0] SEL_BAD   = 2'd3;

    function automatic logic mode_ok(input logic [2:0] m);
        return (m == MODE_ONESHOT) || (m == MODE_RATE) || (m == MODE_SQUARE);
    endfunction

endpackage

// File: rtl/itmr_tick_gen.sv
module itmr_tick_gen #(
    parameter int CLK_HZ  = 50_000_000,
    parameter int TICK_HZ = 1_193_180
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int ACC_W = $clog2(CLK_HZ) + 1;
    localparam logic [ACC_W-1:0] STEP   = ACC_W'(TICK_HZ);
    localparam logic [ACC_W-1:0] THRESH = ACC_W'(CLK_HZ - TICK_HZ);

    logic [ACC_W-1:0] acc;

    assign tick = (acc >= THRESH);

    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (tick)
            acc <= acc - THRESH;
        else
            acc <= acc + STEP;
    end

    // R13: the tick rate is far below the clock, so ticks never come back to back
    p_tick_sparse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/itmr_channel.sv
module itmr_channel
    import itmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              mode_wr,
    input  logic [2:0]        mode_val,
    input  logic              latch_cmd,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [CNT_W/2-1:0] wr_byte,
    output logic [CNT_W/2-1:0] rd_byte,
    output logic              out_level
);
    localparam int BYTE_W = CNT_W / 2;

    ch_state_e        state, state_nx;
    logic [CNT_W-1:0] count, period, latched, new_val;
    logic [2:0]       mode;
    logic             wptr_hi, rptr_hi, latch_held;
    logic             lo_wr, hi_wr, at_one;

    function automatic logic [CNT_W-1:0] half_of(input logic [CNT_W-1:0] v);
        return ((v >> 1) == '0) ? CNT_W'(1) : (v >> 1);
    endfunction

    assign lo_wr   = data_wr && !wptr_hi;
    assign hi_wr   = data_wr && wptr_hi;
    assign new_val = {wr_byte, count[BYTE_W-1:0]};
    assign at_one  = (count == CNT_W'(1));

    // next-state logic
    always_comb begin
        state_nx = state;
        if (lo_wr)
            state_nx = CH_HALT;
        else if (hi_wr)
            state_nx = (new_val != '0) ? CH_RUN : CH_HALT;
        else begin
            unique case (state)
                CH_HALT: state_nx = CH_HALT;
                CH_RUN:  if (tick && mode == MODE_ONESHOT && at_one) state_nx = CH_DONE;
                CH_DONE: state_nx = CH_DONE;
                default: state_nx = CH_HALT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_HALT;
        else        state <= state_nx;
    end

    // datapath and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count      <= '0;
            period     <= '0;
            mode       <= MODE_ONESHOT;
            out_level  <= 1'b0;
            wptr_hi    <= 1'b0;
            rptr_hi    <= 1'b0;
            latch_held <= 1'b0;
            latched    <= '0;
        end else begin
            if (mode_wr) mode <= mode_val;

            if (lo_wr) begin
                count[BYTE_W-1:0] <= wr_byte;
                out_level         <= 1'b0;
                wptr_hi           <= 1'b1;
            end else if (hi_wr) begin
                period  <= new_val;
                count   <= (mode == MODE_SQUARE) ? half_of(new_val) : new_val;
                wptr_hi <= 1'b0;
            end else if (state == CH_RUN && tick) begin
                unique case (mode)
                    MODE_RATE: begin
                        count     <= at_one ? period : count - 1'b1;
                        out_level <= at_one;
                    end
                    MODE_SQUARE: begin
                        count <= at_one ? half_of(period) : count - 1'b1;
                        if (at_one) out_level <= !out_level;
                    end
                    default: begin
                        count <= count - 1'b1;
                        if (at_one) out_level <= 1'b1;
                    end
                endcase
            end

            if (latch_cmd && !latch_held) begin
                latch_held <= 1'b1;
                latched    <= count;
                rptr_hi    <= 1'b0;
            end else if (data_rd) begin
                rptr_hi <= !rptr_hi;
                if (latch_held && rptr_hi) latch_held <= 1'b0;
            end
        end
    end

    always_comb begin
        if (latch_held)
            rd_byte = rptr_hi ? latched[CNT_W-1:BYTE_W] : latched[BYTE_W-1:0];
        else
            rd_byte = rptr_hi ? count[CNT_W-1:BYTE_W] : count[BYTE_W-1:0];
    end

    p_lsb_halts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> (state == CH_HALT && !out_level));

    p_zero_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr && new_val == '0) |=> (state == CH_HALT));

    p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(latch_held) && latch_held) |-> $stable(latched));

    p_oneshot_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_RUN && mode == MODE_ONESHOT && tick && at_one && !data_wr)
        |=> (out_level && state == CH_DONE));

endmodule

// File: rtl/interval_timer3.sv
module interval_timer3
    import itmr_pkg::*;
#(
    parameter int NUM_CH     = 3,
    parameter int CNT_W      = 16,
    parameter int CLK_HZ     = 50_000_000,
    parameter int TICK_HZ    = 1_193_180,
    parameter int SPKR_CH    = 2,
    parameter int STATUS_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              cmd_err,
    output logic [NUM_CH-1:0] ch_out,
    output logic [7:0]        spkr_status
);
    localparam logic [1:0] CTRL_ADDR = 2'd3;

    logic       tick, ctrl_wr, bad_word;
    logic [1:0] sel, acc;
    logic [2:0] mode_f;
    logic       bcd;
    logic [7:0] ch_byte [NUM_CH];
    logic [7:0] rd_mux;

    assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);
    assign sel     = bus_wdata[7:6];
    assign acc     = bus_wdata[5:4];
    assign mode_f  = bus_wdata[3:1];
    assign bcd     = bus_wdata[0];

    always_comb begin
        if (sel == SEL_BAD)
            bad_word = 1'b1;
        else if (acc == ACC_LATCH)
            bad_word = 1'b0;
        else if (acc != ACC_WORD)
            bad_word = 1'b1;
        else
            bad_word = bcd || !mode_ok(mode_f);
    end

    itmr_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit_ctrl, hit_data;
        assign hit_ctrl = ctrl_wr && (sel == 2'(g));
        assign hit_data = (bus_addr == 2'(g));

        itmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .mode_wr   (hit_ctrl && !bad_word && acc == ACC_WORD),
            .mode_val  (mode_f),
            .latch_cmd (hit_ctrl && acc == ACC_LATCH),
            .data_wr   (bus_wr && hit_data),
            .data_rd   (bus_rd && hit_data),
            .wr_byte   (bus_wdata),
            .rd_byte   (ch_byte[g]),
            .out_level (ch_out[g])
        );
    end

    always_comb begin
        rd_mux = 8'h00;
        for (int i = 0; i < NUM_CH; i++)
            if (bus_addr == 2'(i)) rd_mux = ch_byte[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= 8'h00;
            cmd_err   <= 1'b0;
        end else begin
            if (bus_rd) bus_rdata <= rd_mux;
            cmd_err <= ctrl_wr && bad_word;
        end
    end

    always_comb begin
        spkr_status = 8'h00;
        spkr_status[STATUS_BIT] = ch_out[SPKR_CH];
    end

    p_sel_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && sel == SEL_BAD) |=> cmd_err);

    p_access_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && (acc == 2'd1 || acc == 2'd2)) |=> cmd_err);

    p_latch_noerr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && sel != SEL_BAD && acc == ACC_LATCH) |=> !cmd_err);

endmodule

// File: tb/interval_timer3_test.sv
module interval_timer3_test;
    localparam int CLK_HZ  = 50_000_000;
    localparam int TICK_HZ = 1_193_180;

    logic       clk = 0, rst_n = 0;
    logic       bus_wr = 0, bus_rd = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata, spkr_status;
    logic       cmd_err;
    logic [2:0] ch_out;

    interval_timer3 uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmd_err(cmd_err), .ch_out(ch_out), .spkr_status(spkr_status)
    );

    always #10 clk = ~clk;

    int nchk = 0, nerr = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int acc;
    int m_cnt[3], m_per[3], m_mode[3], m_out[3], m_st[3];
    int m_wp[3], m_rp[3], m_lh[3], m_lv[3];
    int m_rd, m_err;
    string m_etag = "R1", m_rtag = "R14";

    function automatic int half(input int p);
        return ((p >> 1) == 0) ? 1 : (p >> 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            acc = 0; m_rd = 0; m_err = 0;
            for (int c = 0; c < 3; c++) begin
                m_cnt[c] = 0; m_per[c] = 0; m_mode[c] = 0; m_out[c] = 0; m_st[c] = 0;
                m_wp[c] = 0; m_rp[c] = 0; m_lh[c] = 0; m_lv[c] = 0;
            end
        end else begin
            bit tk;
            int nm_ch, nm, d, sel, ac, md;
            tk = (acc >= CLK_HZ - TICK_HZ);
            acc = tk ? acc - (CLK_HZ - TICK_HZ) : acc + TICK_HZ;
            m_err = 0; nm_ch = -1; nm = 0;
            d = int'(bus_wdata);
            if (bus_wr && bus_addr == 3) begin
                sel = d >> 6; ac = (d >> 4) & 3; md = (d >> 1) & 7;
                if (sel == 3) begin m_err = 1; m_etag = "R1"; end
                else if (ac == 0) begin
                    if (!m_lh[sel]) begin m_lh[sel] = 1; m_lv[sel] = m_cnt[sel]; m_rp[sel] = 0; end
                end
                else if (ac != 3) begin m_err = 1; m_etag = "R2"; end
                else if ((d & 1) || !(md == 0 || md == 2 || md == 3)) begin m_err = 1; m_etag = "R3"; end
                else begin nm_ch = sel; nm = md; end
            end
            if (bus_rd) begin
                if (bus_addr == 3) begin m_rd = 0; m_rtag = "R8"; end
                else begin
                    int c, v;
                    c = int'(bus_addr);
                    v = m_lh[c] ? m_lv[c] : m_cnt[c];
                    m_rd = m_rp[c] ? (v >> 8) & 255 : v & 255;
                    m_rtag = m_lh[c] ? "R7" : "R8";
                    if (m_lh[c] && m_rp[c]) m_lh[c] = 0;
                    m_rp[c] ^= 1;
                end
            end
            for (int c = 0; c < 3; c++) begin
                if (bus_wr && bus_addr == 2'(c)) begin
                    if (!m_wp[c]) begin
                        m_cnt[c] = (m_cnt[c] & 'hff00) | d;
                        m_out[c] = 0; m_st[c] = 0; m_wp[c] = 1;
                    end else begin
                        int nv;
                        nv = (d << 8) | (m_cnt[c] & 255);
                        m_per[c] = nv;
                        m_cnt[c] = (m_mode[c] == 3) ? half(nv) : nv;
                        m_st[c] = (nv != 0) ? 1 : 0;
                        m_wp[c] = 0;
                    end
                end else if (m_st[c] == 1 && tk) begin
                    if (m_mode[c] == 2) begin
                        if (m_cnt[c] == 1) begin m_cnt[c] = m_per[c]; m_out[c] = 1; end
                        else begin m_cnt[c]--; m_out[c] = 0; end
                    end else if (m_mode[c] == 3) begin
                        if (m_cnt[c] == 1) begin m_cnt[c] = half(m_per[c]); m_out[c] ^= 1; end
                        else m_cnt[c]--;
                    end else begin
                        if (m_cnt[c] == 1) begin m_out[c] = 1; m_st[c] = 2; end
                        m_cnt[c] = (m_cnt[c] - 1) & 'hffff;
                    end
                end
            end
            if (nm_ch >= 0) m_mode[nm_ch] = nm;
        end
    end

    // compare on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < 3; c++) begin
                string t;
                t = (m_st[c] == 0) ? "R4 R5" : (m_mode[c] == 2) ? "R10 R13" :
                    (m_mode[c] == 3) ? "R11 R13" : "R9 R13";
                chk(ch_out[c] == m_out[c][0], $sformatf("%s ch%0d out", t, c), ch_out[c], m_out[c]);
            end
            chk(spkr_status == (m_out[2] ? 8'h20 : 8'h00), "R12 status", spkr_status, m_out[2] ? 'h20 : 0);
            chk(cmd_err == m_err[0], $sformatf("%s cmd_err", m_etag), cmd_err, m_err);
            chk(int'(bus_rdata) == m_rd, $sformatf("%s rdata (R6)", m_rtag), bus_rdata, m_rd);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); bus_wr = 1; bus_addr = 2'(a); bus_wdata = 8'(d);
        @(negedge clk); bus_wr = 0;
    endtask
    task automatic rd(input int a);
        @(negedge clk); bus_rd = 1; bus_addr = 2'(a);
        @(negedge clk); bus_rd = 0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R14: reset state
        chk(ch_out == 3'b000, "R14 outputs", ch_out, 0);
        chk(spkr_status == 8'h00 && cmd_err == 0 && bus_rdata == 8'h00, "R14 status", spkr_status, 0);
        rst_n = 1;
        rd(0); rd(0);
        // R9: mode 0 on channel 0, period 5
        wr(3, 8'h30); wr(0, 5); wr(0, 0);
        rd(0); rd(0);
        idle(300);
        rd(0); rd(0);
        // R10: mode 2 on channel 1, period 3
        wr(3, 8'h74); wr(1, 3); wr(1, 0);
        idle(400);
        // R11 and R12: mode 3 on channel 2, period 4
        wr(3, 8'hB6); wr(2, 4); wr(2, 0);
        idle(500);
        // R6 and R7: latch, ignored second latch, then live reads
        wr(3, 8'h40); idle(100); wr(3, 8'h40);
        rd(1); rd(1); rd(1); rd(1);
        wr(3, 8'h40); rd(1); wr(3, 8'h40); rd(1); rd(1);
        // R5: zero period keeps channel 0 halted
        wr(3, 8'h30); wr(0, 0); wr(0, 0); idle(200);
        // R4: low-byte write mid-run on channel 2
        wr(2, 9); idle(150); wr(2, 0); idle(300);
        // R1 to R3: rejected control words, modes kept
        wr(3, 8'hC0); wr(3, 8'h10); wr(3, 8'h60); wr(3, 8'h78);
        wr(3, 8'hB7); wr(3, 8'hBA); wr(3, 8'h8C);
        idle(300);
        // R8: control address reads zero; large period live reads
        rd(3);
        wr(3, 8'h34); wr(0, 8'h34); wr(0, 8'h12);
        idle(90); rd(0); rd(0); rd(3);
        finish_run();
    end

endmodule